// File: doc/BRIEF.md
# Fine-grained remap access controller

This block sits in a memory controller between a request queue and a non-volatile memory port, and hides per-block remapping from the requester. Each block of `DATA_W` bits (one 64-byte cache line by default) is stored with a one-bit flag kept beside the data. The flag says whether the block holds user data or a forwarding pointer. A worn-out block that has been moved keeps its pointer inside its own still-working cells, as seven replicated 64-bit copies. The controller recovers the pointer by a bitwise majority vote across the copies.

A read fetches the block and its flag. Data goes straight back to the requester. A pointer is decoded, and the read is issued again at the new block address without help from the processor. A pointer always names the final home of the data, so a second pointer found at the new address is a fault, and the controller reports it as an error rather than following it. A write must never land on a block that holds a pointer. Unless the requester states that the line is known to be in place, the controller reads the block first, then writes either in place or at the pointed-to address. Uncached and I/O writes always take the read-first path.

Requests, memory accesses and responses all use valid/ready. A side that holds valid keeps its payload unchanged until ready is seen at a clock edge. The controller takes one request at a time and holds its response until the requester accepts it. The memory side answers reads only, at most one at a time, and the controller samples `mem_rsp_valid` on any cycle while it waits. Every memory write is stored with the flag set to data.

Top module: `rmp_access_ctrl`

## Requirements
- R1: Out of reset, `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0.
- R2: A read of a block whose returned flag is 0 (data) issues exactly one memory read, at the request address. It then responds with that payload, the request tag, `rsp_err`=0, `rsp_remapped`=0 and `rsp_write`=0.
- R3: When a read returns flag 1 (pointer), the voted pointer is taken from copy k in payload bits [64k+63:64k], for k=0..6. Its low `ADDR_W` bits are the new block address. A second read goes to that address, and its data is returned with `rsp_remapped`=1.
- R4: Each pointer bit is the majority of its seven copies, so a pointer is decoded correctly when up to three whole copies are corrupted.
- R5: A pointer at an address reached through a pointer (a chain), or a voted pointer with any bit at or above `ADDR_W` set (out of range), ends the request with `rsp_err`=1 and `rsp_data` all zeros, with no further memory access.
- R6: A write with no known status issues a read first. If the flag is data, it then writes the new payload at the request address.
- R7: A write whose first read returns a pointer issues its single write at the voted address, never at the original address, and responds with `rsp_remapped`=1.
- R8: A cached write with `req_hint_known`=1 and `req_hint_remap`=0 issues its write directly, with no read.
- R9: An uncached write (`req_uncached`=1), or a write with `req_hint_remap`=1, always reads first, whatever the hint says.
- R10: `req_ready` is 0 from the accepting edge until the response is taken. `rsp_valid` and its payload hold until `rsp_ready`. A memory request holds valid, address and direction until `mem_req_ready`.
- R11: A write responds with `rsp_write`=1 only after the memory has accepted the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_uncached | input | 1 | Uncached or I/O write, forces read-first |
| req_hint_known | input | 1 | Requester knows the line's remap status |
| req_hint_remap | input | 1 | Known status: 1 = remapped |
| req_addr | input | ADDR_W | Block address |
| req_tag | input | TAG_W | Request tag, returned with the response |
| req_wdata | input | DATA_W | Write payload |
| mem_req_valid | output | 1 | Memory access valid |
| mem_req_ready | input | 1 | Memory accepts the access |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Memory block address |
| mem_req_wdata | output | DATA_W | Memory write payload |
| mem_rsp_valid | input | 1 | Read data from memory valid |
| mem_rsp_ptr | input | 1 | Stored flag: 1 = pointer, 0 = data |
| mem_rsp_data | input | DATA_W | Read payload |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_write | output | 1 | Response completes a write |
| rsp_err | output | 1 | Chained or out-of-range pointer |
| rsp_remapped | output | 1 | A pointer was followed (can refresh the line's hint) |
| rsp_tag | output | TAG_W | Tag of the request |
| rsp_data | output | DATA_W | Read data (zero for writes and errors) |

## Verification
The bench builds the block with `ADDR_W`=8, `TAG_W`=4 and the default 512-bit block, 64-bit pointer and seven copies. With these values a bench model can hold the whole 256-block memory. Random pointers then often land on other pointer blocks, which brings chains, overwrites of forwarded targets and write-then-read aliasing within reach in a few hundred operations. Random stall patterns on both ready inputs exercise back-pressure at every stage of the sequence.

// File: rtl/rmp_pkg.sv
package rmp_pkg;

  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_RD_ISSUE = 3'd1,
    S_RD_WAIT  = 3'd2,
    S_WR_ISSUE = 3'd3,
    S_RESP     = 3'd4
  } rmp_state_e;

endpackage

// File: rtl/rmp_ptr_vote.sv
module rmp_ptr_vote #(
  parameter int PTR_W  = 64,
  parameter int COPIES = 7
) (
  input  logic [PTR_W*COPIES-1:0] payload,
  output logic [PTR_W-1:0]        ptr
);
  localparam int CNT_W = $clog2(COPIES + 1);
  localparam int HALF  = COPIES / 2;

  for (genvar b = 0; b < PTR_W; b++) begin : g_bit
    logic [CNT_W-1:0] ones;
    always_comb begin
      ones = '0;
      for (int k = 0; k < COPIES; k++) begin
        ones = ones + CNT_W'(payload[k*PTR_W + b]);
      end
    end
    assign ptr[b] = (ones > CNT_W'(HALF));
  end

endmodule

// File: rtl/rmp_seq.sv
module rmp_seq
  import rmp_pkg::*;
#(
  parameter int DATA_W = 512,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_uncached,
  input  logic              req_hint_known,
  input  logic              req_hint_remap,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_ptr,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic [ADDR_W-1:0] ptr_addr,
  input  logic              ptr_oob,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_write,
  output logic              rsp_err,
  output logic              rsp_remapped,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data
);
  rmp_state_e        st;
  logic              r_write;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  logic [DATA_W-1:0] r_rdata;
  logic [TAG_W-1:0]  r_tag;
  logic              r_hop;
  logic              r_err;
  logic              direct_wr;

  // a write may skip the status read only when the line is known to be in place
  assign direct_wr = req_write && req_hint_known && !req_hint_remap && !req_uncached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      r_write <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
      r_rdata <= '0;
      r_tag   <= '0;
      r_hop   <= 1'b0;
      r_err   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            r_write <= req_write;
            r_addr  <= req_addr;
            r_wdata <= req_wdata;
            r_tag   <= req_tag;
            r_rdata <= '0;
            r_hop   <= 1'b0;
            r_err   <= 1'b0;
            st      <= direct_wr ? S_WR_ISSUE : S_RD_ISSUE;
          end
        end
        S_RD_ISSUE: begin
          if (mem_req_ready) st <= S_RD_WAIT;
        end
        S_RD_WAIT: begin
          if (mem_rsp_valid) begin
            if (!mem_rsp_ptr) begin
              if (r_write) begin
                st <= S_WR_ISSUE;
              end else begin
                r_rdata <= mem_rsp_data;
                st      <= S_RESP;
              end
            end else if (r_hop || ptr_oob) begin
              // pointers name the final home: a second one, or one off the device, is a fault
              r_err <= 1'b1;
              st    <= S_RESP;
            end else begin
              r_addr <= ptr_addr;
              r_hop  <= 1'b1;
              st     <= r_write ? S_WR_ISSUE : S_RD_ISSUE;
            end
          end
        end
        S_WR_ISSUE: begin
          if (mem_req_ready) st <= S_RESP;
        end
        S_RESP: begin
          if (rsp_ready) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_RD_ISSUE) || (st == S_WR_ISSUE);
  assign mem_req_write = (st == S_WR_ISSUE);
  assign mem_req_addr  = r_addr;
  assign mem_req_wdata = r_wdata;
  assign rsp_valid     = (st == S_RESP);
  assign rsp_write     = r_write;
  assign rsp_err       = r_err;
  assign rsp_remapped  = r_hop;
  assign rsp_tag       = r_tag;
  assign rsp_data      = r_rdata;

endmodule

// File: rtl/rmp_access_ctrl.sv
module rmp_access_ctrl #(
  parameter int DATA_W     = 512,
  parameter int ADDR_W     = 32,
  parameter int TAG_W      = 8,
  parameter int PTR_W      = 64,
  parameter int PTR_COPIES = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_uncached,
  input  logic              req_hint_known,
  input  logic              req_hint_remap,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_ptr,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_write,
  output logic              rsp_err,
  output logic              rsp_remapped,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int VOTE_W = PTR_W * PTR_COPIES;

  logic [PTR_W-1:0]  voted;
  logic              ptr_oob;

  rmp_ptr_vote #(
    .PTR_W  (PTR_W),
    .COPIES (PTR_COPIES)
  ) u_vote (
    .payload (mem_rsp_data[VOTE_W-1:0]),
    .ptr     (voted)
  );

  if (PTR_W > ADDR_W) begin : g_range
    assign ptr_oob = |voted[PTR_W-1:ADDR_W];
  end else begin : g_norange
    assign ptr_oob = 1'b0;
  end

  rmp_seq #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .TAG_W  (TAG_W)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_write      (req_write),
    .req_uncached   (req_uncached),
    .req_hint_known (req_hint_known),
    .req_hint_remap (req_hint_remap),
    .req_addr       (req_addr),
    .req_tag        (req_tag),
    .req_wdata      (req_wdata),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_write  (mem_req_write),
    .mem_req_addr   (mem_req_addr),
    .mem_req_wdata  (mem_req_wdata),
    .mem_rsp_valid  (mem_rsp_valid),
    .mem_rsp_ptr    (mem_rsp_ptr),
    .mem_rsp_data   (mem_rsp_data),
    .ptr_addr       (voted[ADDR_W-1:0]),
    .ptr_oob        (ptr_oob),
    .rsp_valid      (rsp_valid),
    .rsp_ready      (rsp_ready),
    .rsp_write      (rsp_write),
    .rsp_err        (rsp_err),
    .rsp_remapped   (rsp_remapped),
    .rsp_tag        (rsp_tag),
    .rsp_data       (rsp_data)
  );

endmodule

// File: rtl/rmp_access_chk.sv
module rmp_access_chk #(
  parameter int DATA_W = 512,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_err,
  input logic [TAG_W-1:0]  rsp_tag,
  input logic [DATA_W-1:0] rsp_data
);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> req_ready && !rsp_valid && !mem_req_valid);

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_tag) && $stable(rsp_err) && $stable(rsp_data));

  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_req_valid && !req_ready);

  a_r5_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_data == '0);

  a_r11_write_then_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && mem_req_write |=> rsp_valid);

endmodule

bind rmp_access_ctrl rmp_access_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .TAG_W  (TAG_W)
) u_chk (.*);

// File: tb/rmp_access_ctrl_tb.sv
`timescale 1ns/1ps
module rmp_access_ctrl_tb;
  localparam int DW = 512;
  localparam int AW = 8;
  localparam int TW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_ready, req_write, req_uncached, req_hint_known, req_hint_remap;
  logic [AW-1:0] req_addr;
  logic [TW-1:0] req_tag;
  logic [DW-1:0] req_wdata;
  logic          mem_req_valid, mem_req_ready, mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid, mem_rsp_ptr;
  logic [DW-1:0] mem_rsp_data;
  logic          rsp_valid, rsp_ready, rsp_write, rsp_err, rsp_remapped;
  logic [TW-1:0] rsp_tag;
  logic [DW-1:0] rsp_data;

  rmp_access_ctrl #(.DATA_W(DW), .ADDR_W(AW), .TAG_W(TW)) u_dut (.*);

  int n_pass = 0;
  int n_tot  = 0;

  // memory model state and access log
  logic [DW-1:0] mdata [256];
  logic          mflag [256];
  int            n_rd, n_wr;
  logic [AW-1:0] rd_log [4];
  logic [AW-1:0] wr_log;
  logic [DW-1:0] wr_dlog;
  logic [DW-1:0] pend_data;
  logic          pend_ptr;
  int            lat;

  // expected results of the current operation
  logic [DW-1:0] e_data;
  logic          e_err, e_rm;
  int            e_nrd, e_nwr;
  logic [AW-1:0] e_rd0, e_rd1, e_wa;

  logic [DW-1:0] g_data;
  logic          g_err, g_rm, g_wr;
  logic [TW-1:0] g_tag;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tot++;
    if (ok) n_pass++;
    else $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
  endtask

  function automatic logic [DW-1:0] rnd_blk();
    logic [DW-1:0] d;
    for (int i = 0; i < DW/32; i++) d[i*32 +: 32] = $urandom;
    return d;
  endfunction

  function automatic logic [63:0] vote(input logic [DW-1:0] d);
    logic [63:0] v;
    for (int b = 0; b < 64; b++) begin
      int c = 0;
      for (int k = 0; k < 7; k++) c += int'(d[64*k + b]);
      v[b] = (c >= 4);
    end
    return v;
  endfunction

  function automatic logic [DW-1:0] make_ptr(input logic [63:0] p, input int nbad);
    logic [DW-1:0] d = rnd_blk();
    int s = $urandom % 7;
    for (int k = 0; k < 7; k++) d[64*k +: 64] = p;
    for (int i = 0; i < nbad; i++) d[64*((s+i)%7) +: 64] = {$urandom, $urandom};
    return d;
  endfunction

  // expected behaviour, computed from the requirements and the model contents
  task automatic predict(input bit wr, input logic [AW-1:0] a, input bit hk, input bit hr, input bit uc);
    logic [63:0] p;
    logic [AW-1:0] t;
    e_data = '0; e_err = 0; e_rm = 0; e_nrd = 0; e_nwr = 0;
    e_rd0 = a; e_rd1 = '0; e_wa = a;
    if (wr && hk && !hr && !uc) begin
      e_nwr = 1;
      return;
    end
    e_nrd = 1;
    if (!mflag[a]) begin
      if (wr) e_nwr = 1; else e_data = mdata[a];
      return;
    end
    p = vote(mdata[a]);
    if (p[63:AW] != '0) begin
      e_err = 1;
      return;
    end
    t = p[AW-1:0];
    e_rm = 1;
    if (wr) begin
      e_nwr = 1; e_wa = t;
    end else begin
      e_nrd = 2; e_rd1 = t;
      if (mflag[t]) e_err = 1; else e_data = mdata[t];
    end
  endtask

  task automatic run(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                     input logic [TW-1:0] tg, input bit hk, input bit hr, input bit uc,
                     input string req);
    int t;
    bit ok;
    predict(wr, a, hk, hr, uc);
    @(negedge clk);
    n_rd = 0; n_wr = 0;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd; req_tag = tg;
    req_hint_known = hk; req_hint_remap = hr; req_uncached = uc;
    t = 0;
    while (!req_ready && t < 1000) begin @(negedge clk); t++; end
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R10", "req_ready while busy", DW'(req_ready), '0);
    t = 0; ok = 0;
    while (t < 2000) begin
      rsp_ready = ($urandom % 3) != 0;
      if (rsp_valid && rsp_ready) begin
        g_data = rsp_data; g_err = rsp_err; g_rm = rsp_remapped; g_wr = rsp_write; g_tag = rsp_tag;
        ok = 1;
        break;
      end
      @(negedge clk); t++;
    end
    if (!ok) begin
      chk(0, req, "watchdog: no response", '0, 1);
      return;
    end
    @(negedge clk);
    rsp_ready = 0;
    chk(g_tag == tg, "R10", "tag", DW'(g_tag), DW'(tg));
    chk(g_wr == wr, "R11", "rsp_write", DW'(g_wr), DW'(wr));
    chk(g_err == e_err, req, "err", DW'(g_err), DW'(e_err));
    chk(g_rm == e_rm, req, "remapped", DW'(g_rm), DW'(e_rm));
    chk(g_data == e_data, req, "data", g_data, e_data);
    chk(n_rd == e_nrd, req, "read count", DW'(n_rd), DW'(e_nrd));
    chk(n_wr == e_nwr, req, "write count", DW'(n_wr), DW'(e_nwr));
    if (n_rd >= 1 && e_nrd >= 1) chk(rd_log[0] == e_rd0, req, "first read addr", DW'(rd_log[0]), DW'(e_rd0));
    if (n_rd >= 2 && e_nrd >= 2) chk(rd_log[1] == e_rd1, req, "second read addr", DW'(rd_log[1]), DW'(e_rd1));
    if (n_wr == 1 && e_nwr == 1) begin
      chk(wr_log == e_wa, req, "write addr", DW'(wr_log), DW'(e_wa));
      chk(wr_dlog == wd, req, "write data", wr_dlog, wd);
    end
  endtask

  // memory model: decides ready, logs accesses and returns reads after 1..3 cycles
  initial begin
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_ptr = 0; mem_rsp_data = '0; lat = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          mem_rsp_valid = 1; mem_rsp_data = pend_data; mem_rsp_ptr = pend_ptr;
        end
      end
      mem_req_ready = ($urandom % 4) != 0;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          mdata[mem_req_addr] = mem_req_wdata;
          mflag[mem_req_addr] = 0;
          wr_log = mem_req_addr; wr_dlog = mem_req_wdata;
          n_wr++;
        end else begin
          if (n_rd < 4) rd_log[n_rd] = mem_req_addr;
          n_rd++;
          pend_data = mdata[mem_req_addr]; pend_ptr = mflag[mem_req_addr];
          lat = 1 + int'($urandom % 3);
        end
      end
    end
  end

  initial begin
    logic [DW-1:0] d10, d30, d31;
    void'($urandom(32'h5eed_0042));
    rst_n = 0; req_valid = 0; req_write = 0; req_uncached = 0; req_hint_known = 0;
    req_hint_remap = 0; req_addr = '0; req_tag = '0; req_wdata = '0; rsp_ready = 0;
    n_rd = 0; n_wr = 0;
    for (int i = 0; i < 256; i++) begin
      mflag[i] = ($urandom % 5) == 0;
      mdata[i] = mflag[i] ? make_ptr(64'($urandom % 256), int'($urandom % 4)) : rnd_blk();
    end
    d10 = rnd_blk(); d30 = rnd_blk(); d31 = rnd_blk();
    mdata[10] = d10; mflag[10] = 0;
    mdata[30] = d30; mflag[30] = 0;
    mdata[31] = d31; mflag[31] = 0;
    mdata[20] = make_ptr(64'd30, 0); mflag[20] = 1;
    mdata[21] = make_ptr(64'd31, 3); mflag[21] = 1;
    mdata[22] = make_ptr(64'd20, 1); mflag[22] = 1;
    mdata[23] = make_ptr(64'h100 | 64'd5, 0); mflag[23] = 1;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R1", "req_ready", DW'(req_ready), 1);
    chk(rsp_valid === 1'b0, "R1", "rsp_valid", DW'(rsp_valid), 0);
    chk(mem_req_valid === 1'b0, "R1", "mem_req_valid", DW'(mem_req_valid), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    run(0, 8'd10, '0, 4'h1, 0, 0, 0, "R2");        // plain data block
    run(0, 8'd20, '0, 4'h2, 0, 0, 0, "R3");        // one hop
    run(0, 8'd21, '0, 4'h3, 0, 0, 0, "R4");        // three corrupted copies
    run(0, 8'd22, '0, 4'h4, 0, 0, 0, "R5");        // chain: error after second read
    run(0, 8'd23, '0, 4'h5, 0, 0, 0, "R5");        // out-of-range pointer
    run(1, 8'd10, rnd_blk(), 4'h6, 0, 0, 0, "R6"); // read first, write in place
    run(1, 8'd20, rnd_blk(), 4'h7, 0, 0, 0, "R7"); // write lands at 30
    run(0, 8'd30, '0, 4'h8, 0, 0, 0, "R7");        // data visible at target
    run(1, 8'd40, rnd_blk(), 4'h9, 1, 0, 0, "R8"); // hint skips the read
    run(1, 8'd20, rnd_blk(), 4'hA, 1, 0, 1, "R9"); // uncached ignores the hint
    run(1, 8'd10, rnd_blk(), 4'hB, 1, 1, 0, "R9"); // remapped hint reads first

    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a = AW'($urandom);
      bit wr = $urandom % 2;
      bit hk = ($urandom % 2) && wr;
      bit hr = hk ? mflag[a] : 1'b0;
      bit uc = wr && (($urandom % 4) == 0);
      run(wr, a, rnd_blk(), TW'(n), hk, hr, uc, wr ? "R6/R7" : "R2/R3");
    end

    $display("  %0d/%0d checks passed", n_pass, n_tot);
    $finish;
  end

endmodule